// File: doc/BRIEF.md
# Board Control Register File

This block is a memory-mapped control peripheral for a board. A processor reaches it through a plain read/write strobe bus. Only the low 20 bits of the address select a register. The block holds four groups of state:

- an 8-bit LED bar;
- an eight-character text buffer for a character display;
- an 8-bit general-purpose output;
- a bit-banged two-wire (I2C) port that talks to an attached serial EEPROM.

A write of a magic value to one register raises a single-cycle request for a board reset.

The text buffer can be loaded in two ways. A single 32-bit write turns the word into eight uppercase hex digits. Separate per-position registers each load one character. A sub-window of the offset space belongs to a UART elsewhere on the chip, so this block stays silent there. Every other unknown offset flags an error for one cycle.

The bus carries single register accesses, not a data stream, so there is no valid/ready handshake and no back-pressure. A write lands on the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read.

Top module: `brd_ctrl_regs`

## Requirements
- R1: Only address bits 19:0 select a register; bits above 19 have no effect on reads or writes.
- R2: Offsets 0x900 through 0x9FF are left to a separate UART. An access there changes no state, returns 0 on a read and does not raise `bad_addr`.
- R3: A write to offset 0x408 stores data bits 7:0 in the LED bar. `led_bar[7]` is the leftmost LED and bit 0 is the rightmost. A read of 0x408 returns the stored value.
- R4: A write to offset 0x410 replaces all eight characters with the ASCII uppercase hex digits ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46) of the 32-bit data. Character 0 takes bits 31:28 and character 7 takes bits 3:0. Character k appears on `disp_text[8k+7:8k]`.
- R5: Character k has its own register at offset 0x418 + 8*k, for k from 0 to 7. A write stores data bits 7:0 and a read returns them. A misaligned offset in that range is undecoded.
- R6: During and after reset every character is 0x20 (space). The LED bar, GPO, I2C registers, `bus_rdata`, `bad_addr` and `soft_rst_req` are all 0.
- R7: A write of exactly 0x00000042 to offset 0x500 sets `soft_rst_req` high for the one cycle after the write edge. Any other value written there has no effect.
- R8: The GPO register at 0xA00 keeps 8 data bits, the I2C output-enable register at 0xB08 keeps 2 bits and the I2C select register at 0xB18 keeps 1 bit. Each value is driven on its output and read back zero-extended.
- R9: A write to the I2C output register at 0xB10 drives data bit 1 on `eep_scl` and data bit 0 on `eep_sda`. A read of 0xB10 returns those two bits.
- R10: A read of the I2C input register at 0xB00 returns bit 1 = the stored SCL output and bit 0 = `eep_sda_in` as sampled on the read edge. All other bits are 0.
- R11: An access to any other offset returns 0 on a read, changes no state, and raises `bad_addr` for exactly the one cycle after the access edge.
- R12: Read data is registered: `bus_rdata` changes only in the cycle after a `bus_rd` edge and holds its value otherwise. The offset 0x410 word register and the 0x500 reset register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; low 20 bits decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bad_addr | output | 1 | One-cycle flag for an undecoded access |
| led_bar | output | 8 | LED bar, bit 7 leftmost |
| disp_text | output | 2*DATA_W | Eight display characters, character k at bits 8k+7:8k |
| gp_out | output | 8 | General-purpose output |
| soft_rst_req | output | 1 | One-cycle reset request |
| i2c_oe | output | 2 | I2C output-enable bits |
| i2c_sel | output | 1 | I2C select bit |
| eep_scl | output | 1 | Clock line toward the EEPROM |
| eep_sda | output | 1 | Data line toward the EEPROM |
| eep_sda_in | input | 1 | Data line read back from the EEPROM |

## Verification
The bench goes after these corner cases, each with the fault it would expose:

- **Hex digits across the ten-to-eleven boundary (R4).** The word register is loaded with values whose nibbles cover every digit, including 9, A and F. A digit encoder with the wrong letter offset or the wrong case would print wrong glyphs, and a reversed nibble order would mirror the text.
- **Edges of the character window (R5).** Accesses land on the first and last character offsets, on a misaligned offset inside the window and on the first offset past it. A decoder that truncates the index would alias these onto real characters instead of flagging them.
- **Edges of the UART hole (R2).** Accesses hit 0x900 and 0x9FF. A design that decodes those offsets would either write state or raise a false `bad_addr`.
- **Reset key and input sampling (R7, R10).** Near-miss values are written to the reset register, including a key with a stray high bit, which must not fire. Reads of the I2C input register run while the slave's SDA toggles, which catches a design that samples the line late or returns the stored bit in its place.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam int OFF_W = 20;
  localparam int CHAR_STRIDE_LG = 3;
  typedef logic [OFF_W-1:0] off_t;

  localparam off_t OFF_LED     = 20'h00408;
  localparam off_t OFF_WORD    = 20'h00410;
  localparam off_t OFF_CHAR0   = 20'h00418;
  localparam off_t OFF_SRST    = 20'h00500;
  localparam off_t OFF_UART_LO = 20'h00900;
  localparam off_t OFF_UART_HI = 20'h009FF;
  localparam off_t OFF_GPO     = 20'h00A00;
  localparam off_t OFF_I2C_IN  = 20'h00B00;
  localparam off_t OFF_I2C_OE  = 20'h00B08;
  localparam off_t OFF_I2C_OUT = 20'h00B10;
  localparam off_t OFF_I2C_SEL = 20'h00B18;

  localparam logic [7:0] SRST_KEY = 8'h42;
  localparam logic [7:0] BLANK    = 8'h20;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_UART, SEL_LED, SEL_WORD, SEL_CHAR, SEL_SRST,
    SEL_GPO, SEL_I2C_IN, SEL_I2C_OE, SEL_I2C_OUT, SEL_I2C_SEL
  } bc_sel_e;

  function automatic logic [7:0] hex_glyph(input logic [3:0] n);
    hex_glyph = (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/bc_decode.sv
module bc_decode #(
  parameter int NCHAR = 8,
  parameter int IDX_W = $clog2(NCHAR)
) (
  input  bc_pkg::off_t    off,
  output bc_pkg::bc_sel_e sel,
  output logic [IDX_W-1:0] idx
);
  import bc_pkg::*;
  localparam off_t CHAR_SPAN = off_t'(NCHAR << CHAR_STRIDE_LG);

  off_t diff;

  always_comb begin
    diff = off - OFF_CHAR0;
    sel  = SEL_NONE;
    idx  = '0;
    if (off >= OFF_UART_LO && off <= OFF_UART_HI) begin
      sel = SEL_UART;
    end else if (off >= OFF_CHAR0 && diff < CHAR_SPAN) begin
      if (off[CHAR_STRIDE_LG-1:0] == '0) begin
        sel = SEL_CHAR;
        idx = diff[CHAR_STRIDE_LG +: IDX_W];
      end
    end else begin
      case (off)
        OFF_LED:     sel = SEL_LED;
        OFF_WORD:    sel = SEL_WORD;
        OFF_SRST:    sel = SEL_SRST;
        OFF_GPO:     sel = SEL_GPO;
        OFF_I2C_IN:  sel = SEL_I2C_IN;
        OFF_I2C_OE:  sel = SEL_I2C_OE;
        OFF_I2C_OUT: sel = SEL_I2C_OUT;
        OFF_I2C_SEL: sel = SEL_I2C_SEL;
        default:     sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bc_display.sv
module bc_display #(
  parameter int NCHAR = 8,
  parameter int IDX_W = $clog2(NCHAR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_word,
  input  logic                  wr_char,
  input  logic [IDX_W-1:0]      char_idx,
  input  logic [4*NCHAR-1:0]    wdata,
  output logic [NCHAR-1:0][7:0] chars
);
  import bc_pkg::*;

  for (genvar k = 0; k < NCHAR; k++) begin : g_pos
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chars[k] <= BLANK;
      end else if (wr_word) begin
        chars[k] <= hex_glyph(wdata[4*(NCHAR-1-k) +: 4]);
      end else if (wr_char && char_idx == IDX_W'(k)) begin
        chars[k] <= wdata[7:0];
      end
    end
  end
endmodule

// File: rtl/bc_i2c.sv
module bc_i2c (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_oe,
  input  logic       wr_out,
  input  logic       wr_sel,
  input  logic [1:0] wdata,
  output logic [1:0] oe,
  output logic       scl,
  output logic       sda,
  output logic       sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe  <= '0;
      scl <= 1'b0;
      sda <= 1'b0;
      sel <= 1'b0;
    end else begin
      if (wr_oe)  oe <= wdata;
      if (wr_out) {scl, sda} <= wdata;
      if (wr_sel) sel <= wdata[0];
    end
  end
endmodule

// File: rtl/brd_ctrl_regs.sv
module brd_ctrl_regs #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bad_addr,
  output logic [7:0]          led_bar,
  output logic [2*DATA_W-1:0] disp_text,
  output logic [7:0]          gp_out,
  output logic                soft_rst_req,
  output logic [1:0]          i2c_oe,
  output logic                i2c_sel,
  output logic                eep_scl,
  output logic                eep_sda,
  input  logic                eep_sda_in
);
  import bc_pkg::*;
  localparam int NCHAR = DATA_W / 4;
  localparam int IDX_W = $clog2(NCHAR);

  off_t                  off;
  bc_sel_e               sel;
  logic [IDX_W-1:0]      cidx;
  logic [NCHAR-1:0][7:0] chars;
  logic [DATA_W-1:0]     rd_val;
  logic                  unused_addr_hi;

  assign off            = bus_addr[OFF_W-1:0];
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFF_W];

  bc_decode #(.NCHAR(NCHAR), .IDX_W(IDX_W)) u_dec (
    .off(off), .sel(sel), .idx(cidx)
  );

  bc_display #(.NCHAR(NCHAR), .IDX_W(IDX_W)) u_disp (
    .clk(clk), .rst_n(rst_n),
    .wr_word(bus_wr && sel == SEL_WORD),
    .wr_char(bus_wr && sel == SEL_CHAR),
    .char_idx(cidx), .wdata(bus_wdata[4*NCHAR-1:0]), .chars(chars)
  );

  bc_i2c u_i2c (
    .clk(clk), .rst_n(rst_n),
    .wr_oe(bus_wr && sel == SEL_I2C_OE),
    .wr_out(bus_wr && sel == SEL_I2C_OUT),
    .wr_sel(bus_wr && sel == SEL_I2C_SEL),
    .wdata(bus_wdata[1:0]),
    .oe(i2c_oe), .scl(eep_scl), .sda(eep_sda), .sel(i2c_sel)
  );

  assign disp_text = chars;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_bar      <= '0;
      gp_out       <= '0;
      soft_rst_req <= 1'b0;
    end else begin
      if (bus_wr && sel == SEL_LED) led_bar <= bus_wdata[7:0];
      if (bus_wr && sel == SEL_GPO) gp_out  <= bus_wdata[7:0];
      soft_rst_req <= bus_wr && sel == SEL_SRST && bus_wdata == DATA_W'(SRST_KEY);
    end
  end

  always_comb begin
    case (sel)
      SEL_LED:     rd_val = DATA_W'(led_bar);
      SEL_CHAR:    rd_val = DATA_W'(chars[cidx]);
      SEL_GPO:     rd_val = DATA_W'(gp_out);
      SEL_I2C_IN:  rd_val = DATA_W'({eep_scl, eep_sda_in});
      SEL_I2C_OE:  rd_val = DATA_W'(i2c_oe);
      SEL_I2C_OUT: rd_val = DATA_W'({eep_scl, eep_sda});
      SEL_I2C_SEL: rd_val = DATA_W'(i2c_sel);
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bad_addr  <= 1'b0;
    end else begin
      bad_addr <= (bus_rd || bus_wr) && sel == SEL_NONE;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/bc_regs_chk.sv
module bc_regs_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [19:0]         off,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                bad_addr,
  input logic [7:0]          led_bar,
  input logic [2*DATA_W-1:0] disp_text,
  input logic                soft_rst_req,
  input logic                eep_scl,
  input logic                eep_sda
);
  logic in_uart;
  assign in_uart = off >= 20'h00900 && off <= 20'h009FF;

  p_srst_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> $past(bus_wr) && $past(off) == 20'h00500
                     && $past(bus_wdata) == DATA_W'(8'h42));

  p_bad_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |-> $past(bus_rd || bus_wr));

  p_uart_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && in_uart |=> !bad_addr && $stable(led_bar) && $stable(disp_text));

  p_led_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(led_bar));

  p_text_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(disp_text));

  p_i2c_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable({eep_scl, eep_sda}));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind brd_ctrl_regs bc_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .off(bus_addr[19:0]), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bad_addr(bad_addr), .led_bar(led_bar), .disp_text(disp_text),
  .soft_rst_req(soft_rst_req), .eep_scl(eep_scl), .eep_sda(eep_sda)
);

// File: tb/brd_ctrl_regs_tb.sv
`timescale 1ns/1ps
module brd_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bad_addr, soft_rst_req, i2c_sel, eep_scl, eep_sda;
  logic        eep_sda_in = 1'b0;
  logic [7:0]  led_bar, gp_out;
  logic [63:0] disp_text;
  logic [1:0]  i2c_oe;

  always #4 clk = ~clk;

  brd_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bad_addr(bad_addr), .led_bar(led_bar), .disp_text(disp_text),
    .gp_out(gp_out), .soft_rst_req(soft_rst_req), .i2c_oe(i2c_oe),
    .i2c_sel(i2c_sel), .eep_scl(eep_scl), .eep_sda(eep_sda),
    .eep_sda_in(eep_sda_in)
  );

  int n_cmp = 0, n_bad = 0;
  bit live = 0, done = 0;

  // Behavioural reference model
  byte unsigned m_led, m_gpo, m_txt[8];
  bit [1:0]     m_oe, m_out;
  bit           m_sel, m_srst, m_bad;
  int unsigned  m_rdata;
  string        m_rtag = "R12";
  string        hexd = "0123456789ABCDEF";

  always @(posedge clk) begin
    int unsigned off, rv;
    bit known, uart;
    int idx;
    live <= 1'b1;
    if (!rst_n) begin
      m_led = 0; m_gpo = 0; m_oe = 0; m_out = 0; m_sel = 0;
      m_srst = 0; m_bad = 0; m_rdata = 0;
      foreach (m_txt[i]) m_txt[i] = 8'h20;
    end else begin
      off = {12'h0, bus_addr[19:0]};
      uart = off >= 32'h900 && off <= 32'h9FF;
      known = 1; rv = 0; idx = -1;
      if (off >= 32'h418 && off <= 32'h450 && off % 8 == 0) idx = (off - 32'h418) / 8;
      if (uart) known = 0;
      else if (idx >= 0) rv = m_txt[idx];
      else if (off == 32'h408) rv = m_led;
      else if (off == 32'h410 || off == 32'h500) rv = 0;
      else if (off == 32'hA00) rv = m_gpo;
      else if (off == 32'hB00) rv = {m_out[1], eep_sda_in};
      else if (off == 32'hB08) rv = m_oe;
      else if (off == 32'hB10) rv = m_out;
      else if (off == 32'hB18) rv = m_sel;
      else known = 0;
      m_bad = (bus_rd || bus_wr) && !known && !uart;
      m_srst = 0;
      if (bus_rd) begin
        m_rdata = rv;
        m_rtag = uart ? "R2" : (bus_addr[31:20] != 0) ? "R1" : (off == 32'hB00) ? "R10" : "R12";
      end
      if (bus_wr && !uart) begin
        if (idx >= 0) m_txt[idx] = bus_wdata[7:0];
        else if (off == 32'h408) m_led = bus_wdata[7:0];
        else if (off == 32'h410) for (int k = 0; k < 8; k++) m_txt[k] = hexd[bus_wdata[31-4*k -: 4]];
        else if (off == 32'h500) m_srst = (bus_wdata == 32'h42);
        else if (off == 32'hA00) m_gpo = bus_wdata[7:0];
        else if (off == 32'hB08) m_oe = bus_wdata[1:0];
        else if (off == 32'hB10) m_out = bus_wdata[1:0];
        else if (off == 32'hB18) m_sel = bus_wdata[0];
      end
    end
  end

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [63:0] etxt;
    if (live && !done) begin
      for (int k = 0; k < 8; k++) etxt[8*k +: 8] = m_txt[k];
      if (!rst_n) begin
        cmp("R6 text", disp_text, etxt);
        cmp("R6 regs", {led_bar, gp_out, i2c_oe, i2c_sel, eep_scl, eep_sda, soft_rst_req, bad_addr},
            {m_led, m_gpo, m_oe, m_sel, m_out, m_srst, m_bad});
        cmp("R6 rdata", bus_rdata, m_rdata);
      end else begin
        cmp("R3 led", led_bar, m_led);
        cmp("R4 R5 text", disp_text, etxt);
        cmp("R8 gpo/oe/sel", {gp_out, i2c_oe, i2c_sel}, {m_gpo, m_oe, m_sel});
        cmp("R9 scl/sda", {eep_scl, eep_sda}, m_out);
        cmp("R7 soft_rst_req", soft_rst_req, m_srst);
        cmp("R11 bad_addr", bad_addr, m_bad);
        cmp(m_rtag, bus_rdata, m_rdata);
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [31:0] a);
    @(negedge clk); bus_rd = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2468;
    logic [31:0] offs[16] = '{32'h408, 32'h410, 32'h418, 32'h430, 32'h450, 32'h419,
                              32'h458, 32'h500, 32'h900, 32'h9FF, 32'hA00, 32'hB00,
                              32'hB08, 32'hB10, 32'hB18, 32'hA04};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R6: reset value readback
    rd(32'h418); rd(32'h408);
    // R3 LED bar, upper data bits dropped
    wr(32'h408, 32'h0000_01A5); rd(32'h408);
    // R4 hex word, every digit class
    wr(32'h410, 32'h1234_ABCD); rd(32'h418); rd(32'h450);
    wr(32'h410, 32'h90F0_9E5A); rd(32'h420);
    wr(32'h410, 32'hFEDC_BA98);
    // R5 single characters, window edges
    wr(32'h418, 32'h41); wr(32'h450, 32'h17A); rd(32'h450); rd(32'h418);
    // R11 misaligned / past window / random holes
    wr(32'h419, 32'h55); rd(32'h458); wr(32'hA04, 32'h1); rd(32'h0);
    // R7 reset key and near misses
    wr(32'h500, 32'h42); wr(32'h500, 32'h43); wr(32'h500, 32'h142);
    wr(32'h500, 32'h42); wr(32'h500, 32'h42); rd(32'h500);
    // R8 GPO, OE, SEL
    wr(32'hA00, 32'h3C5); wr(32'hB08, 32'hFF); wr(32'hB18, 32'hFE); wr(32'hB18, 32'h3);
    rd(32'hA00); rd(32'hB08); rd(32'hB18);
    // R9 I2C output lines
    wr(32'hB10, 32'h2); rd(32'hB10); wr(32'hB10, 32'h1); wr(32'hB10, 32'h3); rd(32'hB10);
    // R10 input register with toggling slave SDA
    eep_sda_in = 1; rd(32'hB00); eep_sda_in = 0; rd(32'hB00);
    wr(32'hB10, 32'h0); eep_sda_in = 1; rd(32'hB00);
    // R2 UART hole edges
    wr(32'h900, 32'hFF); wr(32'h9FF, 32'h42); rd(32'h900); rd(32'h9FF);
    // R1 aliasing through upper address bits
    wr(32'hFFF0_0408, 32'h3C); rd(32'h1230_0408); wr(32'h8000_0500, 32'h42);
    // mixed traffic, back to back
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      eep_sda_in = lfsr[7];
      @(negedge clk);
      bus_addr  = {lfsr[31:28] == 4'h5 ? 12'hABC : 12'h0, offs[lfsr[3:0]][19:0]};
      bus_wdata = lfsr[9] ? 32'h42 : lfsr;
      bus_wr    = lfsr[4];
      bus_rd    = !lfsr[4] && lfsr[5];
    end
    @(negedge clk); bus_wr = 0; bus_rd = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule